// File: doc/BRIEF.md
# Console Character Register Block

This block puts a character console on a processor's load/store bus as four word-aligned registers inside a small address window. Two registers serve the keyboard direction: a control word and a data word. The other two serve the display direction in the same way. The device side takes a keyboard byte with a one-cycle strobe. It hands a display byte out with a one-cycle strobe, and it takes back a one-cycle pulse when the display has finished with that byte.

Software can poll the ready flag in each control word, or it can set the enable bit in that word so that the ready condition drives an interrupt line. Ready flags change only through side effects. A load of the keyboard data word clears keyboard ready. A store to the display data word clears display ready. The device strobes set the flags.

The device-side streams apply no back-pressure. A keyboard strobe is always accepted. A display strobe is always taken, and the display ready flag is the only flow control for software. Bus accesses complete in one cycle. Read data is combinational from the registers, and all side effects take place at the clock edge that ends the access.

Top module: `console_regs`

## Requirements
- R1: The window starts at BASE_ADDR (default 0xFFFF0000) and holds four registers: keyboard control at +0x0, keyboard data at +0x4, display control at +0x8 and display data at +0xC. A read returns the selected register on `bus_rdata` in the same cycle.
- R2: In both control words, bit 0 is the ready flag and bit 1 is the interrupt enable. All other bits read as 0.
- R3: After a `kbd_valid` strobe, keyboard ready reads 1 from the next cycle on, and the byte reads back in bits 7:0 of keyboard data, with bits 31:8 reading as 0.
- R4: A load from keyboard data clears keyboard ready for the following cycles. If a keyboard strobe arrives in the same cycle as that load, ready stays 1, the load returns the old byte, and the new byte is stored.
- R5: A keyboard byte that arrives while keyboard ready is still 1 replaces the stored byte, and ready stays 1.
- R6: A store to display data produces `disp_valid` for exactly one cycle, in the cycle after the store, with bits 7:0 of the stored word on `disp_data`. The store also clears display ready, and a later read of display data returns that byte.
- R7: Display ready is 1 after reset. It reads 1 in the cycle after a `disp_done` pulse. If a store to display data falls in the same cycle as `disp_done`, the store wins and ready is 0.
- R8: Software stores to a control word change only the enable bit, taken from bit 1 of the written value. The ready flag is not affected.
- R9: `irq_kbd` is 1 exactly when keyboard ready and keyboard enable are both 1. `irq_disp` follows the same rule for the display direction.
- R10: After reset, keyboard ready is 0, both enables are 0, both interrupt lines are 0 and `disp_valid` is 0.
- R11: An access outside the window, or at an address whose bits 1:0 are not zero, has no effect and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data (combinational) |
| kbd_valid | input | 1 | Keyboard byte strobe |
| kbd_data | input | 8 | Keyboard byte |
| disp_valid | output | 1 | Display byte strobe |
| disp_data | output | 8 | Display byte |
| disp_done | input | 1 | Display finished pulse |
| irq_kbd | output | 1 | Keyboard interrupt request |
| irq_disp | output | 1 | Display interrupt request |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a keyboard strobe landing on the exact cycle of a keyboard-data load. The other is a display-done pulse landing on the exact cycle of a display-data store. In both, the order of set and clear decides the flag. The bench drives the bus signals and the device strobe together on a single falling edge, so that both are sampled at the same rising edge. It then reads the control word back to see which side won. Display bytes go through a scoreboard queue, so any strobe that a stray or misaligned store produces shows up as an unexpected item.

// File: rtl/console_pkg.sv
package console_pkg;

  // Register index within the window: bus address bits 3:2
  typedef enum logic [1:0] {
    REG_KBD_CTRL  = 2'd0,
    REG_KBD_DATA  = 2'd1,
    REG_DISP_CTRL = 2'd2,
    REG_DISP_DATA = 2'd3
  } reg_sel_e;

  localparam int RDY_BIT = 0;
  localparam int IE_BIT  = 1;

  // Decoded bus operation
  typedef struct packed {
    logic     rd;
    logic     wr;
    reg_sel_e sel;
  } bus_op_t;

endpackage

// File: rtl/console_decode.sv
module console_decode
  import console_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output bus_op_t           op
);
  localparam int WIN_LSB = 4;
  localparam logic [ADDR_W-1:0] BASE_W = BASE_ADDR[ADDR_W-1:0];

  logic hit;

  always_comb begin
    hit    = bus_sel
           && (bus_addr[ADDR_W-1:WIN_LSB] == BASE_W[ADDR_W-1:WIN_LSB])
           && (bus_addr[1:0] == 2'b00);
    op.rd  = hit && !bus_we;
    op.wr  = hit && bus_we;
    op.sel = reg_sel_e'(bus_addr[3:2]);
  end

endmodule

// File: rtl/console_kbd_chan.sv
module console_kbd_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_data,
  input  logic              ctrl_wr,
  input  logic              ie_wval,
  input  logic              data_rd,
  output logic              ready,
  output logic              ie,
  output logic [CHAR_W-1:0] char_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready  <= 1'b0;
      ie     <= 1'b0;
      char_q <= '0;
    end else begin
      if (ctrl_wr) ie <= ie_wval;
      // A byte arriving is newer than the one being read: set wins
      if (kbd_valid) begin
        char_q <= kbd_data;
        ready  <= 1'b1;
      end else if (data_rd) begin
        ready  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/console_disp_chan.sv
module console_disp_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ie_wval,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wchar,
  input  logic              disp_done,
  output logic              ready,
  output logic              ie,
  output logic [CHAR_W-1:0] char_q,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready      <= 1'b1;
      ie         <= 1'b0;
      char_q     <= '0;
      disp_valid <= 1'b0;
      disp_data  <= '0;
    end else begin
      if (ctrl_wr) ie <= ie_wval;
      disp_valid <= data_wr;
      if (data_wr) begin
        char_q    <= wchar;
        disp_data <= wchar;
        ready     <= 1'b0;
      end else if (disp_done) begin
        ready     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/console_regs.sv
module console_regs
  import console_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          CHAR_W    = 8,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_data,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_data,
  input  logic              disp_done,
  output logic              irq_kbd,
  output logic              irq_disp
);
  bus_op_t op;
  logic kbd_rdy, kbd_ie, disp_rdy, disp_ie;
  logic [CHAR_W-1:0] kbd_char, disp_char;
  logic wdata_spare;

  console_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .op      (op)
  );

  console_kbd_chan #(.CHAR_W(CHAR_W)) u_kbd (
    .clk      (clk),
    .rst_n    (rst_n),
    .kbd_valid(kbd_valid),
    .kbd_data (kbd_data),
    .ctrl_wr  (op.wr && op.sel == REG_KBD_CTRL),
    .ie_wval  (bus_wdata[IE_BIT]),
    .data_rd  (op.rd && op.sel == REG_KBD_DATA),
    .ready    (kbd_rdy),
    .ie       (kbd_ie),
    .char_q   (kbd_char)
  );

  console_disp_chan #(.CHAR_W(CHAR_W)) u_disp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (op.wr && op.sel == REG_DISP_CTRL),
    .ie_wval   (bus_wdata[IE_BIT]),
    .data_wr   (op.wr && op.sel == REG_DISP_DATA),
    .wchar     (bus_wdata[CHAR_W-1:0]),
    .disp_done (disp_done),
    .ready     (disp_rdy),
    .ie        (disp_ie),
    .char_q    (disp_char),
    .disp_valid(disp_valid),
    .disp_data (disp_data)
  );

  // Store-data bits beyond the byte and the enable are not kept
  assign wdata_spare = ^bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (op.rd) begin
      unique case (op.sel)
        REG_KBD_CTRL: begin
          bus_rdata[RDY_BIT] = kbd_rdy;
          bus_rdata[IE_BIT]  = kbd_ie;
        end
        REG_KBD_DATA:  bus_rdata[CHAR_W-1:0] = kbd_char;
        REG_DISP_CTRL: begin
          bus_rdata[RDY_BIT] = disp_rdy;
          bus_rdata[IE_BIT]  = disp_ie;
        end
        REG_DISP_DATA: bus_rdata[CHAR_W-1:0] = disp_char;
        default:       bus_rdata = '0;
      endcase
    end
  end

  assign irq_kbd  = kbd_rdy && kbd_ie;
  assign irq_disp = disp_rdy && disp_ie;

endmodule

// File: rtl/console_regs_checker.sv
module console_regs_checker #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          CHAR_W    = 8,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              kbd_valid,
  input logic              disp_valid,
  input logic [CHAR_W-1:0] disp_data,
  input logic              disp_done,
  input logic              kbd_rdy,
  input logic              disp_rdy,
  input logic              irq_kbd,
  input logic              irq_disp
);
  localparam logic [ADDR_W-1:0] B = BASE_ADDR[ADDR_W-1:0];

  logic acc_ok;
  logic wr_kctl, rd_kdat, wr_ddat;
  assign acc_ok  = bus_sel && (bus_addr[ADDR_W-1:4] == B[ADDR_W-1:4]) && (bus_addr[1:0] == 2'b00);
  assign wr_kctl = acc_ok && bus_we && (bus_addr[3:2] == 2'd0);
  assign rd_kdat = acc_ok && !bus_we && (bus_addr[3:2] == 2'd1);
  assign wr_ddat = acc_ok && bus_we && (bus_addr[3:2] == 2'd3);

  assert_kbd_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid |=> kbd_rdy);

  assert_kbd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_kdat && !kbd_valid) |=> !kbd_rdy);

  assert_disp_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ddat |=> (disp_valid && !disp_rdy && disp_data == $past(bus_wdata[CHAR_W-1:0])));

  assert_disp_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_done && !wr_ddat) |=> disp_rdy);

  assert_ready_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kctl && !kbd_valid) |=> (kbd_rdy == $past(kbd_rdy)));

  assert_irq_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_kbd || irq_disp) |-> ((irq_kbd ? kbd_rdy : 1'b1) && (irq_disp ? disp_rdy : 1'b1)));

endmodule

bind console_regs console_regs_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .BASE_ADDR(BASE_ADDR)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .kbd_valid (kbd_valid),
  .disp_valid(disp_valid),
  .disp_data (disp_data),
  .disp_done (disp_done),
  .kbd_rdy   (kbd_rdy),
  .disp_rdy  (disp_rdy),
  .irq_kbd   (irq_kbd),
  .irq_disp  (irq_disp)
);

// File: tb/console_regs_bench.sv
module console_regs_bench;
  localparam logic [31:0] BASE = 32'hFFFF_0000;
  localparam logic [31:0] A_KC = BASE + 32'h0;
  localparam logic [31:0] A_KD = BASE + 32'h4;
  localparam logic [31:0] A_DC = BASE + 32'h8;
  localparam logic [31:0] A_DD = BASE + 32'hC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic kbd_valid = 1'b0;
  logic [7:0] kbd_data = '0;
  logic disp_valid, disp_done = 1'b0;
  logic [7:0] disp_data;
  logic irq_kbd, irq_disp;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [31:0] rv;

  always #5 clk = ~clk;

  console_regs u_console_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kbd_valid(kbd_valid), .kbd_data(kbd_data),
    .disp_valid(disp_valid), .disp_data(disp_data), .disp_done(disp_done),
    .irq_kbd(irq_kbd), .irq_disp(irq_disp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected display bytes as strobes appear
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected display strobe actual=%h expected=none", disp_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (disp_data !== e) begin
          errors++;
          $display("FAIL R6 display byte actual=%h expected=%h", disp_data, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == A_DD) exp_q.push_back(d[7:0]);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic key(input logic [7:0] b);
    @(negedge clk);
    kbd_valid = 1'b1; kbd_data = b;
    @(negedge clk);
    kbd_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    disp_done = 1'b1;
    @(negedge clk);
    disp_done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 / R2: reset state
    chk("R10 irq_kbd", {31'd0, irq_kbd}, 32'd0);
    chk("R10 irq_disp", {31'd0, irq_disp}, 32'd0);
    chk("R10 disp_valid", {31'd0, disp_valid}, 32'd0);
    bus_read(A_KC, rv); chk("R10 R2 kbd ctrl", rv, 32'h0);
    bus_read(A_DC, rv); chk("R7 R2 disp ctrl after reset", rv, 32'h1);

    // R3 / R1 / R4
    key(8'h41);
    bus_read(A_KC, rv); chk("R3 kbd ready", rv, 32'h1);
    bus_read(A_KD, rv); chk("R3 R1 kbd data", rv, 32'h41);
    bus_read(A_KC, rv); chk("R4 ready cleared", rv, 32'h0);

    // R5 overwrite
    key(8'h42); key(8'h43);
    bus_read(A_KC, rv); chk("R5 ready stays", rv, 32'h1);
    bus_read(A_KD, rv); chk("R5 newest byte", rv, 32'h43);

    // R8 / R9
    bus_write(A_KC, 32'hFFFF_FFFF);
    bus_read(A_KC, rv); chk("R8 ready not set by write", rv, 32'h2);
    chk("R9 irq_kbd low without ready", {31'd0, irq_kbd}, 32'd0);
    key(8'h55);
    chk("R9 irq_kbd high", {31'd0, irq_kbd}, 32'd1);
    bus_read(A_KC, rv); chk("R2 kbd ctrl both", rv, 32'h3);
    bus_write(A_KC, 32'h0000_0001);
    bus_read(A_KC, rv); chk("R8 ready not cleared by write", rv, 32'h1);
    chk("R9 irq_kbd off with enable", {31'd0, irq_kbd}, 32'd0);

    // R4 collision: load and new byte in same cycle
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_KD;
    kbd_valid = 1'b1; kbd_data = 8'h66;
    #1 chk("R4 collision returns old byte", bus_rdata, 32'h55);
    @(negedge clk);
    bus_sel = 1'b0; kbd_valid = 1'b0;
    bus_read(A_KC, rv); chk("R4 collision ready kept", rv, 32'h1);
    bus_read(A_KD, rv); chk("R4 collision new byte", rv, 32'h66);

    // R6 / R7 / R9 display side
    bus_write(A_DD, 32'h1234_01A5);
    bus_read(A_DC, rv); chk("R6 disp ready cleared", rv, 32'h0);
    bus_read(A_DD, rv); chk("R6 disp data readback", rv, 32'hA5);
    bus_write(A_DC, 32'h2);
    chk("R9 irq_disp low", {31'd0, irq_disp}, 32'd0);
    done_pulse();
    chk("R7 R9 irq_disp after done", {31'd0, irq_disp}, 32'd1);
    bus_read(A_DC, rv); chk("R7 disp ctrl after done", rv, 32'h3);

    // R7 collision: store and done in same cycle
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_DD; bus_wdata = 32'h3C;
    exp_q.push_back(8'h3C);
    disp_done = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; disp_done = 1'b0;
    bus_read(A_DC, rv); chk("R7 store beats done", rv, 32'h2);
    done_pulse();
    bus_read(A_DC, rv); chk("R7 ready back", rv, 32'h3);

    // R11: outside window and misaligned
    bus_write(BASE + 32'h10, 32'h77);
    bus_write(BASE + 32'hD, 32'h78);
    bus_write(BASE - 32'h4, 32'h79);
    bus_read(BASE + 32'h10, rv); chk("R11 out of window reads 0", rv, 32'h0);
    bus_read(BASE + 32'h9, rv); chk("R11 misaligned reads 0", rv, 32'h0);
    bus_read(A_DC, rv); chk("R11 disp ctrl unchanged", rv, 32'h3);
    bus_read(A_DD, rv); chk("R11 disp data unchanged", rv, 32'h3C);

    // Stream pattern through the scoreboard
    for (int i = 0; i < 8; i++) begin
      bus_write(A_DD, 32'(8'h30 + i * 7));
      done_pulse();
    end
    repeat (3) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule